// File: doc/BRIEF.md
# Collision Backoff Slot Timer

This block sets the retransmission delay of a serial link controller that shares its medium under carrier-sense multiple access with collision detection. Every collision reported by the transmitter makes the block select a whole number of slots to wait. It then counts that wait down in bit times, paced by a bit-rate clock enable. When the wait ends, it gives a single-cycle strobe that permits the frame to be sent again. The length of a slot is set in bit times by an 8-bit value, and a value of zero selects 256 bit times.

One 8-bit count register has two roles. In random backoff mode it counts the collisions of the current frame. The delay is then drawn from a pseudo-random generator over a window that doubles with each collision. Software clears the count before it starts a new frame, so that a fresh frame can be told apart from a retry. In fixed backoff mode, software loads the register with a slot count, and every collision waits exactly that many slots. A frame-start strobe cancels a wait that is still pending.

Top module: `csma_backoff_timer`

## Requirements
- R1: After reset, `coll_cnt_o` is 0, `backoff_o` is 0 and `retx_o` is 0.
- R2: A slot lasts N bit times. N is `slot_len_i`, except that 0 selects 256. A bit time is one cycle with `bit_en_i` high.
- R3: In random mode (`det_mode_i`=0), each `coll_i` pulse increments `coll_cnt_o` by one. The count saturates at 255.
- R4: In random mode, the wait in slots is L AND (2^min(c,8)−1). Here c is the count after the increment, and L is the low byte of a 16-bit Fibonacci LFSR as it stands in the collision cycle. The LFSR starts at 0xACE1 after reset and shifts left once every clock, taking bit15^bit13^bit12^bit10 into bit 0.
- R5: In fixed mode (`det_mode_i`=1), the wait in slots equals `coll_cnt_o`, and a collision leaves the count unchanged. `cnt_load_i` writes `cnt_data_i` into the count in either mode.
- R6: `backoff_o` rises in the cycle after a collision. It falls at the edge of the last bit time of the last slot, which is the (slots×N)-th bit enable. A wait of zero slots ends at the first bit enable.
- R7: `retx_o` is high for exactly one cycle, the cycle in which `backoff_o` has just fallen because the wait expired.
- R8: A collision during an active wait restarts the wait, using the updated count and a new random draw. Only one `retx_o` pulse follows.
- R9: `cnt_clr_i` sets the count to 0. It takes priority over `cnt_load_i` and over the collision increment.
- R10: `frame_start_i` ends an active wait with no `retx_o` pulse. A collision in the same cycle takes priority over it.
- R11: `bit_en_i` has no effect while no wait is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per bit time |
| slot_len_i | input | 8 | Slot length in bit times, 0 means 256 |
| det_mode_i | input | 1 | 0 selects random backoff, 1 selects fixed backoff |
| coll_i | input | 1 | Collision strobe |
| frame_start_i | input | 1 | Frame start strobe, cancels a pending wait |
| cnt_clr_i | input | 1 | Clears the count register |
| cnt_load_i | input | 1 | Loads the count register |
| cnt_data_i | input | 8 | Value for a count load |
| coll_cnt_o | output | 8 | Collision count, or the slot count in fixed mode |
| backoff_o | output | 1 | A wait is in progress |
| retx_o | output | 1 | Retransmission permitted, one-cycle strobe |

## Verification
Fixed mode is tried with slot counts of 0, 2 and 1. The last of these runs with a slot length of 0, which separates the multiplication of slots by N from the 256 decoding and from the zero-slot shortcut. Random mode is tried with collisions spaced apart, so that the growing window shows up in the draws, and then with collisions close together from a preloaded count of 254. The close collisions exercise both the restart and the saturation. Separate cases cover a frame start that cancels a wait and a clear that coincides with a collision. These tell cancellation and clear priority apart from normal expiry. A behavioural model that counts total remaining bit times is compared with all outputs on every cycle.

// File: rtl/csma_bo_pkg.sv
package csma_bo_pkg;
  typedef enum logic {
    BO_RANDOM = 1'b0,
    BO_FIXED  = 1'b1
  } bo_mode_e;
endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr #(
  parameter int unsigned         W     = 16,
  parameter int unsigned         OUT_W = 8,
  parameter logic [W-1:0]        TAPS  = 16'hB400,
  parameter logic [W-1:0]        SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & TAPS);
  assign rnd_o = state_q[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], fb};
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);
endmodule

// File: rtl/coll_count_reg.sv
module coll_count_reg #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] data_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_inc_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;

  assign cnt_o     = cnt_q;
  assign cnt_inc_o = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= data_i;
    else if (inc_i)  cnt_q <= cnt_inc_o;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !load_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> cnt_q == '0);
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int unsigned CW = 8,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic [LW-1:0] slot_len_i,
  input  logic          start_i,
  input  logic [CW-1:0] slots_i,
  input  logic          abort_i,
  output logic          active_o,
  output logic          retx_o
);
  localparam int unsigned BW = LW + 1;

  logic [BW-1:0] len_dec;
  logic [BW-1:0] bit_q;
  logic [CW-1:0] slot_q;
  logic          act_q, retx_q;

  // zero selects 2^LW bit times
  assign len_dec  = (slot_len_i == '0) ? BW'(1) << LW : {1'b0, slot_len_i};
  assign active_o = act_q;
  assign retx_o   = retx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      retx_q <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      retx_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        slot_q <= slots_i;
        bit_q  <= len_dec;
      end else if (abort_i) begin
        act_q <= 1'b0;
      end else if (act_q && bit_en_i) begin
        if (slot_q == '0) begin
          act_q  <= 1'b0;
          retx_q <= 1'b1;
        end else if (bit_q == BW'(1)) begin
          bit_q <= len_dec;
          if (slot_q == CW'(1)) begin
            act_q  <= 1'b0;
            retx_q <= 1'b1;
          end else begin
            slot_q <= slot_q - 1'b1;
          end
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end

  // R6
  start_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> act_q);
  // R7
  retx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) retx_q |=> !retx_q);
  // R7
  retx_after_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retx_q) |-> $fell(act_q));
  // R10
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i) |=> (!act_q && !retx_q));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !start_i) |=> (!act_q && !retx_q));
endmodule

// File: rtl/csma_backoff_timer.sv
module csma_backoff_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned LW      = 8,
  parameter int unsigned EXP_MAX = 8,
  parameter int unsigned RND_W   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic [LW-1:0] slot_len_i,
  input  logic          det_mode_i,
  input  logic          coll_i,
  input  logic          frame_start_i,
  input  logic          cnt_clr_i,
  input  logic          cnt_load_i,
  input  logic [CW-1:0] cnt_data_i,
  output logic [CW-1:0] coll_cnt_o,
  output logic          backoff_o,
  output logic          retx_o
);
  import csma_bo_pkg::*;

  bo_mode_e      mode;
  logic [CW-1:0] cnt, cnt_inc, rnd, mask, slots;
  logic          inc;

  assign mode = bo_mode_e'(det_mode_i);
  assign inc  = coll_i && (mode == BO_RANDOM);

  backoff_lfsr #(.W(RND_W), .OUT_W(CW)) u_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd)
  );

  coll_count_reg #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(cnt_clr_i), .load_i(cnt_load_i), .data_i(cnt_data_i),
    .inc_i(inc), .cnt_o(cnt), .cnt_inc_o(cnt_inc)
  );

  // window bit i open when min(count,EXP_MAX) > i
  for (genvar i = 0; i < CW; i++) begin : g_mask
    if (i < EXP_MAX) begin : g_on
      assign mask[i] = cnt_inc > CW'(i);
    end else begin : g_off
      assign mask[i] = 1'b0;
    end
  end

  assign slots = (mode == BO_FIXED) ? cnt : (rnd & mask);

  slot_timer #(.CW(CW), .LW(LW)) u_tmr (
    .clk_i, .rst_ni, .bit_en_i, .slot_len_i,
    .start_i(coll_i), .slots_i(slots), .abort_i(frame_start_i),
    .active_o(backoff_o), .retx_o
  );

  assign coll_cnt_o = cnt;

  // R5
  fixed_cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && det_mode_i && !cnt_clr_i && !cnt_load_i) |=> $stable(coll_cnt_o));
  // R3
  rand_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && !det_mode_i && !cnt_clr_i && !cnt_load_i && coll_cnt_o != '1)
      |=> coll_cnt_o == $past(coll_cnt_o) + 1'b1);
endmodule

// File: tb/csma_backoff_timer_test.sv
module csma_backoff_timer_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bit_en = 1'b0, det = 1'b0, coll = 1'b0, fstart = 1'b0, clr = 1'b0, load = 1'b0;
  logic [7:0] slot_len = 8'd3, ldata = 8'd0;
  logic [7:0] cnt;
  logic       act, retx;
  int         errors = 0, checks = 0, div = 0, retx_seen = 0;

  always #2 clk = ~clk;

  csma_backoff_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .slot_len_i(slot_len),
    .det_mode_i(det), .coll_i(coll), .frame_start_i(fstart), .cnt_clr_i(clr),
    .cnt_load_i(load), .cnt_data_i(ldata), .coll_cnt_o(cnt), .backoff_o(act), .retx_o(retx)
  );

  // reference model: total remaining bit times
  int m_cnt, m_act, m_retx, m_rem, m_lfsr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_retx = 0; m_rem = 0; m_lfsr = 16'hACE1;
    end else begin
      int lf, fb, c1, k, sl, n;
      lf = m_lfsr;
      fb = ((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1;
      m_lfsr = ((lf << 1) | fb) & 16'hFFFF;
      n = (slot_len == 0) ? 256 : int'(slot_len);
      m_retx = 0;
      if (coll) begin
        if (!det) begin
          c1 = (m_cnt == 255) ? 255 : m_cnt + 1;
          k = (c1 > 8) ? 8 : c1;
          sl = (lf & 255) & ((1 << k) - 1);
        end else sl = m_cnt;
        m_rem = (sl == 0) ? 1 : sl * n;
        m_act = 1;
      end else if (fstart) m_act = 0;
      else if (m_act == 1 && bit_en) begin
        m_rem--;
        if (m_rem == 0) begin m_act = 0; m_retx = 1; end
      end
      if (clr) m_cnt = 0;
      else if (load) m_cnt = int'(ldata);
      else if (coll && !det) m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expect_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expect_v, $time);
    end
  endtask

  always @(negedge clk) begin
    bit_en <= (div == 0);
    div <= (div == 1) ? 0 : div + 1;
    if (rst_n) begin
      check(int'(cnt) == m_cnt, "R3/R5/R9 count", int'(cnt), m_cnt);
      check(int'(act) == m_act, "R6 backoff_o", int'(act), m_act);
      check(int'(retx) == m_retx, "R7 retx_o", int'(retx), m_retx);
      if (retx) retx_seen++;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: coll = 1'b1;
      1: fstart = 1'b1;
      2: clr = 1'b1;
      default: load = 1'b1;
    endcase
    @(negedge clk);
    coll = 1'b0; fstart = 1'b0; clr = 1'b0; load = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && act; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check(cnt == 0 && !act && !retx, "R1 reset state", int'(act), 0);
    rst_n = 1'b1;
    // R11: idle bit enables
    repeat (20) @(negedge clk);
    check(!act && retx_seen == 0, "R11 idle", retx_seen, 0);
    // R5: fixed mode, 2 slots
    det = 1'b1; ldata = 8'd2; pulse(3);
    r0 = retx_seen; pulse(0); wait_idle();
    check(retx_seen == r0 + 1 && cnt == 2, "R5 fixed wait", retx_seen - r0, 1);
    // R6: zero slots
    ldata = 8'd0; pulse(3); r0 = retx_seen; pulse(0); wait_idle();
    check(retx_seen == r0 + 1, "R6 zero slots", retx_seen - r0, 1);
    // R2: slot length 0 -> 256
    slot_len = 8'd0; ldata = 8'd1; pulse(3); r0 = retx_seen; pulse(0); wait_idle();
    check(retx_seen == r0 + 1, "R2 long slot", retx_seen - r0, 1);
    slot_len = 8'd3;
    // R3 R4: random mode, spaced collisions
    det = 1'b0; pulse(2);
    for (int i = 0; i < 4; i++) begin pulse(0); wait_idle(); end
    check(cnt == 4, "R3 count after four", int'(cnt), 4);
    // R8: restart during active wait
    r0 = retx_seen; pulse(0); repeat (2) @(negedge clk); pulse(0); wait_idle();
    check(retx_seen == r0 + 1, "R8 restart single retx", retx_seen - r0, 1);
    // R10: frame start cancels
    det = 1'b1; ldata = 8'd5; pulse(3); r0 = retx_seen;
    pulse(0); repeat (4) @(negedge clk); pulse(1); repeat (40) @(negedge clk);
    check(!act && retx_seen == r0, "R10 cancel", retx_seen - r0, 0);
    // R3: saturation via close collisions
    det = 1'b0; ldata = 8'd254; pulse(3);
    pulse(0); pulse(0); pulse(0); wait_idle();
    check(cnt == 255, "R3 saturate", int'(cnt), 255);
    // R9: clear wins over increment
    @(negedge clk); coll = 1'b1; clr = 1'b1; load = 1'b1; ldata = 8'd9;
    @(negedge clk); coll = 1'b0; clr = 1'b0; load = 1'b0;
    check(cnt == 0, "R9 clear priority", int'(cnt), 0);
    wait_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule